// File: doc/BRIEF.md
# Operand Effective-Address Resolver

This block turns the operand bytes of an 8-bit processor instruction into a 16-bit effective address. The decoder supplies an addressing-mode code, the one or two operand bytes, the two index registers and the address of the first operand byte. For modes that need no memory pointer, the block registers the result and reports it on the next cycle. For modes that go through a pointer in memory, the block fetches the pointer one byte at a time over a byte-wide read port and then reports the result.

Besides the address, the block reports how many operand bytes the instruction used, so the sequencer can advance its program counter. A one-cycle `done` strobe marks a valid result. All request inputs are captured on the `start` cycle, so the caller may change them while a fetch is in flight. The block does not perform the data access itself.

Top module: `ea_resolver`

## Requirements
- R1: Mode code 0 (page zero) gives address {0x00, lo} and an operand length of 1. `lo` is the first operand byte and `hi` is the second.
- R2: Mode codes 1 (page zero plus X) and 2 (page zero plus Y) give {0x00, (lo + index) mod 256}. The sum never leaves page zero. The operand length is 1.
- R3: Mode code 3 gives {hi, lo}. Mode codes 4 and 5 add X or Y to that 16-bit value modulo 65536, so a carry reaches the high byte. All three have an operand length of 2.
- R4: Mode code 6 (index-before-pointer) forms p = (lo + X) mod 256. It reads the low pointer byte at {0x00, p} and the high byte at {0x00, (p + 1) mod 256}. The result is {high, low} and the operand length is 1.
- R5: Mode code 7 (index-after-pointer) reads the low byte at {0x00, lo} and the high byte at {0x00, (lo + 1) mod 256}. The result is ({high, low} + Y) mod 65536 and the operand length is 1.
- R6: Mode code 8 (page-zero pointer) reads the same two locations as R5 and returns {high, low} with no index added. The operand length is 1.
- R7: Mode code 9 (branch target) gives (pc + 1 + sign-extended lo) mod 65536, where pc is the address of the offset byte. The operand length is 1.
- R8: Mode code 10 reads the low byte at P = {hi, lo} and the high byte at (P + 1) mod 65536. Mode code 11 does the same with P = ({hi, lo} + X) mod 65536. Both return {high, low} with an operand length of 2.
- R9: Pointer bytes are read low first, then high, one byte per accepted read. A read is accepted on a clock edge where `rd_req` and `rd_valid` are both high. `rd_req` stays high with a stable `rd_addr` until it is accepted. Modes 0-5 and 9 issue no reads.
- R10: `done` is high for exactly one cycle. It rises on the edge after `start` for modes 0-5 and 9, and on the edge after the last pointer byte is accepted for modes 6-8, 10 and 11.
- R11: A `start` that arrives while a request is in progress is ignored. It does not change the result in flight and does not produce a second `done`.
- R12: While `rst_n` is low, `done` and `rd_req` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a resolution; sampled only when idle |
| mode | input | 4 | Addressing-mode code (0-11) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the first operand byte |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte address |
| rd_valid | input | 1 | Read data valid; accepts the current request |
| rd_data | input | 8 | Read data byte |
| ea | output | 16 | Effective address, valid with done |
| op_len | output | 2 | Operand bytes consumed, valid with done |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default byte width of 8, which makes the address 16 bits wide. At that width every first-operand value from 0 to 255 can be swept through all twelve mode codes. The index values follow a different step, so the page-zero wraps, the high-byte carries and the pointer at the very top of memory are all reached. Read latency cycles through 0, 1 and 2 wait cycles, which exercises the hold rule of the handshake and the `done` timing at every latency.

// File: rtl/ea_resolver_pkg.sv
package ea_resolver_pkg;
  typedef enum logic [3:0] {
    AM_ZP      = 4'd0,
    AM_ZPX     = 4'd1,
    AM_ZPY     = 4'd2,
    AM_ABS     = 4'd3,
    AM_ABSX    = 4'd4,
    AM_ABSY    = 4'd5,
    AM_PREIDX  = 4'd6,
    AM_POSTIDX = 4'd7,
    AM_ZPIND   = 4'd8,
    AM_REL     = 4'd9,
    AM_JIND    = 4'd10,
    AM_JIDX    = 4'd11
  } am_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } seq_e;
endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_resolver_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [AW-1:0] pc_i,
  output logic          is_ind_o,
  output logic          ptr_zp_o,
  output logic [AW-1:0] ptr0_o,
  output logic [AW-1:0] ptr1_o,
  output logic [DW-1:0] add_o,
  output logic [AW-1:0] ea_o,
  output logic [1:0]    len_o
);
  localparam logic [DW-1:0] ZPAGE = '0;

  logic [DW-1:0] zp_x, zp_y, zp_x1, zp_1;
  logic [AW-1:0] abs_v, abs_x, offs;

  always_comb begin
    zp_x  = op_lo_i + x_i;
    zp_y  = op_lo_i + y_i;
    zp_x1 = zp_x + DW'(1);
    zp_1  = op_lo_i + DW'(1);
    abs_v = {op_hi_i, op_lo_i};
    abs_x = abs_v + {ZPAGE, x_i};
    offs  = {{DW{op_lo_i[DW-1]}}, op_lo_i};
  end

  always_comb begin
    is_ind_o = 1'b0;
    ptr_zp_o = 1'b0;
    ptr0_o   = '0;
    ptr1_o   = '0;
    add_o    = '0;
    ea_o     = {ZPAGE, op_lo_i};
    len_o    = 2'd1;
    case (am_e'(mode_i))
      AM_ZPX:  ea_o = {ZPAGE, zp_x};
      AM_ZPY:  ea_o = {ZPAGE, zp_y};
      AM_ABS: begin
        ea_o  = abs_v;
        len_o = 2'd2;
      end
      AM_ABSX: begin
        ea_o  = abs_x;
        len_o = 2'd2;
      end
      AM_ABSY: begin
        ea_o  = abs_v + {ZPAGE, y_i};
        len_o = 2'd2;
      end
      AM_PREIDX: begin
        is_ind_o = 1'b1;
        ptr_zp_o = 1'b1;
        ptr0_o   = {ZPAGE, zp_x};
        ptr1_o   = {ZPAGE, zp_x1};
      end
      AM_POSTIDX, AM_ZPIND: begin
        is_ind_o = 1'b1;
        ptr_zp_o = 1'b1;
        ptr0_o   = {ZPAGE, op_lo_i};
        ptr1_o   = {ZPAGE, zp_1};
        add_o    = (am_e'(mode_i) == AM_POSTIDX) ? y_i : '0;
      end
      AM_REL:  ea_o = pc_i + AW'(1) + offs;
      AM_JIND: begin
        is_ind_o = 1'b1;
        ptr0_o   = abs_v;
        ptr1_o   = abs_v + AW'(1);
        len_o    = 2'd2;
      end
      AM_JIDX: begin
        is_ind_o = 1'b1;
        ptr0_o   = abs_x;
        ptr1_o   = abs_x + AW'(1);
        len_o    = 2'd2;
      end
      default: ea_o = {ZPAGE, op_lo_i};
    endcase
  end
endmodule

// File: rtl/ea_ptr_fsm.sv
module ea_ptr_fsm
  import ea_resolver_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_ind_i,
  input  logic          ptr_zp_i,
  input  logic [AW-1:0] ptr0_i,
  input  logic [AW-1:0] ptr1_i,
  input  logic [DW-1:0] add_i,
  input  logic [AW-1:0] ea_d_i,
  input  logic [1:0]    len_d_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] ea_o,
  output logic [1:0]    len_o,
  output logic          done_o
);
  seq_e          st_q, st_d;
  logic [AW-1:0] p0_q, p1_q, ea_q, ea_d;
  logic [DW-1:0] add_q, lo_q;
  logic [1:0]    len_q;
  logic          zp_q;
  logic          cap_en, lo_en, ea_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    lo_en  = 1'b0;
    ea_en  = 1'b0;
    ea_d   = ea_d_i;
    case (st_q)
      ST_IDLE: if (start_i) begin
        cap_en = 1'b1;
        ea_en  = !is_ind_i;
        st_d   = is_ind_i ? ST_LO : ST_FIN;
      end
      ST_LO: if (rd_valid_i) begin
        lo_en = 1'b1;
        st_d  = ST_HI;
      end
      ST_HI: if (rd_valid_i) begin
        ea_en = 1'b1;
        ea_d  = {rd_data_i, lo_q} + {{DW{1'b0}}, add_q};
        st_d  = ST_FIN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      p0_q  <= ptr0_i;
      p1_q  <= ptr1_i;
      add_q <= add_i;
      zp_q  <= ptr_zp_i;
      len_q <= len_d_i;
    end
    if (lo_en) lo_q <= rd_data_i;
    if (ea_en) ea_q <= ea_d;
  end

  assign rd_req_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign rd_addr_o = (st_q == ST_HI) ? p1_q : p0_q;
  assign done_o    = (st_q == ST_FIN);
  assign ea_o      = ea_q;
  assign len_o     = len_q;

  a_r9_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && $past(rd_req_o) |-> $past(rd_valid_i));
  a_r4_ptr_in_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && zp_q |-> rd_addr_o[AW-1:DW] == '0);
  a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o == 2'd1 || len_o == 2'd2));
  a_r11_no_req_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ea,
  output logic [1:0]    op_len,
  output logic          done
);
  logic          is_ind, ptr_zp;
  logic [AW-1:0] ptr0, ptr1, ea_d;
  logic [DW-1:0] add_v;
  logic [1:0]    len_d;

  ea_direct_calc #(.DW(DW)) calc_i (
    .mode_i(mode), .op_lo_i(opnd_lo), .op_hi_i(opnd_hi),
    .x_i(idx_x), .y_i(idx_y), .pc_i(pc),
    .is_ind_o(is_ind), .ptr_zp_o(ptr_zp), .ptr0_o(ptr0), .ptr1_o(ptr1),
    .add_o(add_v), .ea_o(ea_d), .len_o(len_d)
  );

  ea_ptr_fsm #(.DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .is_ind_i(is_ind), .ptr_zp_i(ptr_zp), .ptr0_i(ptr0), .ptr1_i(ptr1),
    .add_i(add_v), .ea_d_i(ea_d), .len_d_i(len_d),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid),
    .rd_data_i(rd_data), .ea_o(ea), .len_o(op_len), .done_o(done)
  );

  a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(start));
endmodule

// File: tb/ea_resolver_tb_top.sv
`timescale 1ns/1ps
module ea_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc = '0;
  logic        rd_req, rd_valid = 1'b0;
  logic [15:0] rd_addr, ea;
  logic [7:0]  rd_data = '0;
  logic [1:0]  op_len;
  logic        done;

  int total = 0, bad = 0, lat = 0, nrd = 0, wcnt = 0;
  logic [15:0] rda [0:1];
  bit finished = 0;

  always #2.5 clk = ~clk;

  ea_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .pc(pc), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .ea(ea), .op_len(op_len), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] * 8'd5 + a[15:8] * 8'd3 + 8'h11;
  endfunction

  // memory responder: drives away from the active edge
  always @(negedge clk) begin
    if (rd_req) begin
      if (wcnt >= lat) begin
        rd_valid = 1'b1;
        rd_data  = memf(rd_addr);
        if (nrd < 2) rda[nrd] = rd_addr;
        nrd++;
        wcnt = 0;
      end else begin
        rd_valid = 1'b0;
        wcnt++;
      end
    end else begin
      rd_valid = 1'b0;
      wcnt = 0;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";
      1, 2: return "R2";
      3, 4, 5: return "R3";
      6: return "R4";
      7: return "R5";
      8: return "R6";
      9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_one(input int m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y,
                         input logic [15:0] p, input bit poke);
    logic [15:0] e, a0, a1, base;
    logic [7:0]  t, t1;
    int n, ln, cyc, expcyc;
    bit seen;
    n = 0; ln = 1; a0 = '0; a1 = '0; e = '0;
    case (m)
      0: e = {8'h00, lo};
      1: begin t = lo + x; e = {8'h00, t}; end
      2: begin t = lo + y; e = {8'h00, t}; end
      3: begin e = {hi, lo}; ln = 2; end
      4: begin e = {hi, lo} + {8'h00, x}; ln = 2; end
      5: begin e = {hi, lo} + {8'h00, y}; ln = 2; end
      6: begin t = lo + x; t1 = t + 8'd1; a0 = {8'h00, t}; a1 = {8'h00, t1}; n = 2; end
      7, 8: begin t1 = lo + 8'd1; a0 = {8'h00, lo}; a1 = {8'h00, t1}; n = 2; end
      9: e = p + 16'd1 + {{8{lo[7]}}, lo};
      10: begin a0 = {hi, lo}; a1 = a0 + 16'd1; n = 2; ln = 2; end
      default: begin base = {hi, lo} + {8'h00, x}; a0 = base; a1 = base + 16'd1; n = 2; ln = 2; end
    endcase
    if (n == 2) begin
      e = {memf(a1), memf(a0)};
      if (m == 7) e = e + {8'h00, y};
    end
    expcyc = (n == 0) ? 1 : 1 + 2 * (lat + 1);

    @(negedge clk);
    mode = 4'(m); opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p;
    start = 1'b1; nrd = 0;
    cyc = 0; seen = 0;
    while (cyc < 20 && !seen) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        if (poke) begin mode = 4'd0; opnd_lo = ~lo; idx_x = ~x; end
        else start = 1'b0;
      end
      if (cyc == 2) start = 1'b0;
      if (done) seen = 1;
    end
    check("R10", "done seen", 32'(seen), 32'd1);
    check("R10", "done latency", 32'(cyc), 32'(expcyc));
    check(tag_of(m), "ea", 32'(ea), 32'(e));
    check(tag_of(m), "op_len", 32'(op_len), 32'(ln));
    check("R9", "read count", 32'(nrd), 32'(n));
    if (n == 2) begin
      check(tag_of(m), "low pointer address", 32'(rda[0]), 32'(a0));
      check(tag_of(m), "high pointer address", 32'(rda[1]), 32'(a1));
    end
    @(negedge clk);
    check("R10", "done one cycle", 32'(done), 32'd0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R11", "no second done", 32'(done), 32'd0);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "done in reset", 32'(done), 32'd0);
    check("R12", "rd_req in reset", 32'(rd_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // corner cases
    lat = 0;
    run_one(6, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0000, 0); // R4: pointer at 0xFF wraps to 0x00
    run_one(7, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0000, 0); // R5: wrap plus carry
    run_one(8, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0000, 0); // R6
    run_one(10, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, 0); // R8: pointer 0xFFFF
    run_one(4, 8'hFF, 8'h12, 8'h01, 8'h00, 16'h0000, 0); // R3: carry into high byte
    run_one(9, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0010, 0); // R7: backward branch
    run_one(9, 8'h7F, 8'h00, 8'h00, 8'h00, 16'hFFF0, 0); // R7: wrap past top
    lat = 2;
    run_one(7, 8'h40, 8'h00, 8'h00, 8'h22, 16'h0000, 1); // R11: start while busy
    lat = 0;
    run_one(11, 8'h10, 8'h20, 8'h33, 8'h00, 16'h0000, 1); // R11

    // sweep
    for (int m = 0; m < 12; m++) begin
      for (int v = 0; v < 256; v++) begin
        lat = v % 3;
        run_one(m, 8'(v), 8'(v * 3 + 1), 8'(v * 7 + 128), 8'(v * 11 + 64),
                {8'(v), ~8'(v)}, 0);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule